// File: doc/BRIEF.md
# Keyed watchdog reset controller

This peripheral watches over a chip and requests a full-chip reset when software stops servicing it. It sits on a simple register bus and exposes three 32-bit registers: a control register that holds a two-bit reset-configuration field, a status register that keeps reset-cause and boot-hint bits, and a countdown register holding a 20-bit timeout. Software loads a timeout, then arms the timer by setting the configuration field to full-reset mode. It keeps the chip alive by reloading the count before it runs out.

Every bus write must carry the key byte 0x5A in bits [31:24]. A write with any other key is dropped silently. This protects the reset path against stray stores. When the count runs out while armed, the block drives a reset request for a fixed number of cycles. It then disarms itself and sets a cause flag in the status register. Only the power-on reset clears the status register, so hint bits that software writes before a deliberate reset are still there when the chip comes back up.

The count advances once per tick, and one tick is `TICK_DIV` clock cycles. Register offsets are 0x1C (control), 0x20 (status) and 0x24 (count).

Top module: `wdg_rstctl_top`

## Requirements
- R1: After power-on reset (`por_n` low) all three registers read zero and `rst_req_o` is low. `bus_ready` equals `bus_valid` in the same cycle.
- R2: A write whose bits [31:24] differ from 0x5A leaves the control, status and count registers unchanged.
- R3: Reads are combinational. Control returns bits [23:0] and status returns bits [23:0], both zero-extended. Count returns the live count in bits [19:0]. Any offset other than 0x1C, 0x20 or 0x24 reads zero and ignores writes.
- R4: The timer is armed while control bit 5 is set, which is the top bit of the configuration field [5:4]; the value 2'b10 means full reset. While disarmed, the count holds its value.
- R5: While armed, the count drops by one every `TICK_DIV` cycles. The tick divider restarts on arming and on each count write. With count N ≥ 1 loaded, `rst_req_o` rises N·`TICK_DIV` clock edges after the arming write.
- R6: A keyed write to the count register reloads the count at once, even while armed, and restarts the timeout from the new value.
- R7: On expiry, `rst_req_o` stays high for exactly `PULSE_LEN` cycles. Control bits [5:4] clear and the other control bits are kept, so no second request follows.
- R8: Expiry sets status bit 5 (watchdog-fired cause). The other status bits are left unchanged.
- R9: A keyed write of 0x102 to control clears the configuration field. The count then stops and no reset request is made.
- R10: Status bits survive the reset request; for example, the halt hint pattern 0x555 spread over bits 0, 2, 4, 6, 8 and 10 is kept. Only `por_n` clears them.
- R11: Arming with a count of zero raises `rst_req_o` after one tick, i.e. `TICK_DIV` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Request accepted (same cycle) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data; [31:24] carries the key |
| bus_rdata | output | 32 | Read data |
| rst_req_o | output | 1 | Full-chip reset request pulse |

## Verification
The countdown is run with several loaded values, including zero and a small non-zero count. The cycle at which the request rises tells an off-by-one in the divider apart from an off-by-one in the count. A reload part-way through the countdown separates a true restart from a count that only adds time. A stop write part-way through shows that disarming freezes the count rather than clearing it. Writes with a wrong key, and writes to an unmapped offset, are each followed by readback of all registers, which shows that nothing was touched. Hint bits written before expiry are read back afterwards, which separates status retention from a status register cleared by the request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned REG_W    = 24;
  localparam int unsigned CNT_W    = 20;
  localparam logic [7:0]  KEY      = 8'h5A;
  localparam logic [7:0]  OFF_CTRL = 8'h1C;
  localparam logic [7:0]  OFF_STAT = 8'h20;
  localparam logic [7:0]  OFF_CNT  = 8'h24;
  localparam int unsigned ARM_BIT  = 5;
  localparam int unsigned CFG_LO   = 4;
  localparam int unsigned CAUSE_BIT = 5;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CNT} reg_sel_e;

  function automatic logic key_ok(input logic [DATA_W-1:0] wd);
    return wd[DATA_W-1 -: 8] == KEY;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  function automatic logic last_tick(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction
endpackage

// File: rtl/wdg_bus_decode.sv
module wdg_bus_decode
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        key_byte,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_cnt
);
  logic wr_ok;

  always_comb begin
    if (addr == ADDR_W'(OFF_CTRL))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
    else                                sel = SEL_NONE;
  end

  assign wr_ok   = valid && write && key_ok({key_byte, 24'h0});
  assign wr_ctrl = wr_ok && (sel == SEL_CTRL);
  assign wr_stat = wr_ok && (sel == SEL_STAT);
  assign wr_cnt  = wr_ok && (sel == SEL_CNT);

  // R3: at most one register is written per request
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl, wr_stat, wr_cnt}));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             tick,
  output logic             expire
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (!armed || load)   pre_q <= '0;
    else if (pre_q == PRE_TOP) pre_q <= '0;
    else                       pre_q <= pre_q + PRE_W'(1);
  end

  assign tick   = armed && !load && (pre_q == PRE_TOP);
  assign expire = tick && last_tick(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else if (tick) count_q <= cnt_step(count_q);
  end

  a_r4_hold_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(count_q));
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1)));
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int unsigned LEN_W = $clog2(PULSE_LEN + 2);

  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= LEN_W'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - LEN_W'(1);
  end

  assign req = (left_q != '0);

  // observation counter for the width check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (req) run_q <= run_q + LEN_W'(1);
    else          run_q <= '0;
  end

  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(fire));
  a_r7_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> (run_q == LEN_W'(PULSE_LEN)));
endmodule

// File: rtl/wdg_rstctl_top.sv
module wdg_rstctl_top
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 16,
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req_o
);
  reg_sel_e         sel;
  logic             wr_ctrl, wr_stat, wr_cnt;
  logic [REG_W-1:0] ctrl_q, stat_q, ctrl_d, stat_d;
  logic [CNT_W-1:0] count_q;
  logic             armed, tick, expire;

  wdg_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(por_n), .valid(bus_valid), .write(bus_write),
    .addr(bus_addr), .key_byte(bus_wdata[31:24]), .sel(sel),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_cnt(wr_cnt));

  assign armed = ctrl_q[ARM_BIT];

  wdg_countdown #(.TICK_DIV(TICK_DIV)) u_cnt (
    .clk(clk), .rst_n(por_n), .armed(armed), .load(wr_cnt),
    .load_val(bus_wdata[CNT_W-1:0]), .count_q(count_q), .tick(tick),
    .expire(expire));

  wdg_reset_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(por_n), .fire(expire), .req(rst_req_o));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = bus_wdata[REG_W-1:0];
    if (expire)  ctrl_d[CFG_LO +: 2] = 2'b00;
    stat_d = stat_q;
    if (wr_stat) stat_d = bus_wdata[REG_W-1:0];
    if (expire)  stat_d[CAUSE_BIT] = 1'b1;
  end

  // only power-on reset touches these; the request output does not
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  assign bus_ready = bus_valid;

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = {8'h00, ctrl_q};
      SEL_STAT: bus_rdata = {8'h00, stat_q};
      SEL_CNT:  bus_rdata = {{(32-CNT_W){1'b0}}, count_q};
      default:  bus_rdata = '0;
    endcase
  end

  a_r2_ctrl_guard: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(ctrl_q) |-> $past((bus_valid && bus_write &&
      bus_wdata[31:24] == KEY) || expire));
  a_r2_stat_guard: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(stat_q) |-> $past((bus_valid && bus_write &&
      bus_wdata[31:24] == KEY) || expire));
  a_r7_cfg_clear: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> (ctrl_q[CFG_LO +: 2] == 2'b00));
  a_r8_cause_set: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> stat_q[CAUSE_BIT]);
  a_r4_no_tick_disarmed: assert property (@(posedge clk) disable iff (!por_n)
    !armed |-> !tick);
endmodule

// File: tb/tb_wdg_rstctl_top.sv
`timescale 1ns/1ps
module tb_wdg_rstctl_top;
  localparam int D = 4;
  localparam int PL = 4;
  localparam logic [7:0] A_CTRL = 8'h1C, A_STAT = 8'h20, A_CNT = 8'h24;

  logic clk = 1'b0, por_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rst_req_o;
  logic [31:0] bus_rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdg_rstctl_top #(.TICK_DIV(D), .PULSE_LEN(PL), .ADDR_W(8)) dut (
    .clk(clk), .por_n(por_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req_o(rst_req_o));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    if (bus_ready !== 1'b1) chk("R1 ready", {31'b0, bus_ready}, 32'd1);
    #0.5;
    bus_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // counts edges after the current point until the request rises, then its width
  task automatic wait_req(input string req, input int exp_k, input int mid_k,
                          input logic [31:0] mid_exp);
    int k = 0, w = 0;
    logic [31:0] d;
    while (rst_req_o !== 1'b1 && k < exp_k + 40) begin
      @(negedge clk); k++;
      if (k == mid_k) begin rd(A_CNT, d); chk({req, " mid count"}, d, mid_exp); end
    end
    chk({req, " rise edge"}, k, exp_k);
    while (rst_req_o === 1'b1 && w < 40) begin @(negedge clk); w++; end
    chk("R7 pulse width", w, PL);
  endtask

  task automatic quiet(input string req, input int cycles);
    int hi = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (rst_req_o) hi++; end
    chk(req, hi, 0);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 0); rd_chk("R1 stat", A_STAT, 0);
    rd_chk("R1 count", A_CNT, 0); chk("R1 req", {31'b0, rst_req_o}, 0);
  endtask

  task automatic t_key;
    wr(A_CTRL, 32'h1100_0020); wr(A_STAT, 32'hA500_0555); wr(A_CNT, 32'h5B00_00FF);
    rd_chk("R2 ctrl", A_CTRL, 0); rd_chk("R2 stat", A_STAT, 0); rd_chk("R2 count", A_CNT, 0);
    quiet("R2 no request", 3 * D);
  endtask

  task automatic t_readback;
    wr(A_CTRL, 32'h5AFF_1203); rd_chk("R3 ctrl", A_CTRL, 32'h00FF_1203);
    wr(A_STAT, 32'h5A12_3456); rd_chk("R3 stat", A_STAT, 32'h0012_3456);
    wr(A_CNT, 32'h5AFF_FFFF);  rd_chk("R3 count", A_CNT, 32'h000F_FFFF);
    wr(8'h28, 32'h5A00_0020);
    rd_chk("R3 unmapped", 8'h28, 0); rd_chk("R3 unmapped 0", 8'h00, 0);
    rd_chk("R3 ctrl after unmapped", A_CTRL, 32'h00FF_1203);
    repeat (5 * D) @(negedge clk);
    rd_chk("R4 disarmed hold", A_CNT, 32'h000F_FFFF);
  endtask

  task automatic t_expire;
    logic [31:0] c;
    wr(A_CNT, 32'h5A00_0003);
    rd(A_CTRL, c);
    wr(A_CTRL, 32'h5A00_0000 | (c & 32'h00FF_FFCF) | 32'h20);
    wait_req("R5 count 3", 3 * D, D, 32'd2);
    rd_chk("R7 ctrl cfg cleared", A_CTRL, 32'h00FF_1203);
    rd_chk("R8 cause set", A_STAT, 32'h0012_3476);
    rd_chk("R7 count at zero", A_CNT, 0);
    quiet("R7 no repeat", 4 * D);
  endtask

  task automatic t_keepalive;
    wr(A_CNT, 32'h5A00_0002);
    wr(A_CTRL, 32'h5AFF_1223);
    repeat (3) @(negedge clk);
    wr(A_CNT, 32'h5A00_0002);
    wait_req("R6 reload", 2 * D, -1, 0);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    wr(A_CNT, 32'h5A00_0009);
    wr(A_CTRL, 32'h5AFF_1223);
    repeat (D + 1) @(negedge clk);
    wr(A_CTRL, 32'h5A00_0102);
    rd_chk("R9 ctrl", A_CTRL, 32'h0000_0102);
    rd(A_CNT, a);
    quiet("R9 no request", 20 * D);
    rd(A_CNT, b);
    chk("R9 count frozen", b, a);
    chk("R9 count not cleared", {31'b0, (a != 0)}, 1);
  endtask

  task automatic t_zero;
    wr(A_CNT, 32'h5A00_0000);
    wr(A_CTRL, 32'h5A00_0020);
    wait_req("R11 zero count", D, -1, 0);
  endtask

  task automatic t_hints;
    wr(A_STAT, 32'h5A00_0555);
    wr(A_CNT, 32'h5A00_0001);
    wr(A_CTRL, 32'h5A00_0030);
    wait_req("R5 count 1", D, -1, 0);
    rd_chk("R10 hints kept", A_STAT, 32'h0000_0575);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    rd_chk("R10 por clears stat", A_STAT, 0);
    rd_chk("R1 por clears ctrl", A_CTRL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    t_reset(); t_key(); t_readback(); t_expire();
    t_keepalive(); t_stop(); t_zero(); t_hints();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk);
        n_run++; n_fail++; $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule